// File: doc/BRIEF.md
# Framebuffer Rectangle Fill and Bitmap Expander

This block is a small register-driven drawing engine for an 8-bit-per-pixel linear framebuffer that is 1280 pixels wide and 1024 lines high. Software programs two corner points, a colour, a framebuffer base address and an operation code over a 32-bit register port. A write to one trigger register then paints a solid rectangle. A write to another expands a 32-bit monochrome mask word into coloured pixels inside the rectangle. A third operation clears a linear byte range to zero.

All pixel and clearing traffic leaves through a single memory write port. The engine raises a request and holds the address, size and data steady until the memory acknowledges. Byte writes carry their data in the low eight bits. Wide writes are 64 bits and always aligned to 8 bytes. While an operation runs the engine reports busy, and it ignores every further start request.

Top module: `gfx_fill_engine`

## Requirements
- R1: Register word indexes are taken from `reg_addr[5:2]`: 0 operation, 1 colour, 2 corner A, 3 corner B, 4 framebuffer base, 5 clear-first, 6 clear-last, 7 fill trigger, 8 pixel trigger (the written data is the mask), 9 command, 10 status (bit 0 = busy). After reset every register reads zero and no memory request is raised.
- R2: A corner register holds x in bits 27:16 and y in bits 11:0. Each pixel is a byte write to base + x + y*1280 whose data is colour bits 7:0.
- R3: A write to the fill trigger paints the rectangle only when bits 31:24 of the operation register equal 3. With any other code the trigger produces no memory write.
- R4: The corners are ordered automatically: the smaller x and the smaller y become the start. Both edges are included, and pixels are visited in raster order (x fastest).
- R5: Pixels with x >= 1280 or y >= 1024 are skipped without a memory write.
- R6: Pixel expansion gives each rectangle pixel, in raster order, the next mask bit starting at bit 31. Only pixels whose bit is 1 are written, and pixels beyond the 32nd get no write.
- R7: When the ordered width (x_hi - x_lo) is 15 or less, the mask is shifted left by 16 before use. At 16 or more it is used as written.
- R8: Writing 0x11 to the command register clears every byte from clear-first through clear-last, inclusive. Other command values do nothing, and so does clear-last < clear-first.
- R9: The clear uses 64-bit writes (`mem_wide` = 1) at every 8-aligned address whose 8 bytes lie in the range, and byte writes elsewhere.
- R10: Busy reads 1 from the cycle after a start until the last write is acknowledged. Fill, pixel and command triggers that arrive while busy are ignored.
- R11: A raised request keeps its address, size and data unchanged until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| mem_req | output | 1 | Memory write request |
| mem_wide | output | 1 | 1 = 64-bit write, 0 = byte write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 64 | Write data, a byte write uses bits 7:0 |
| mem_ack | input | 1 | Memory accepts the current request |

## Verification
The hold and range assertions assume `mem_ack` is only ever high while a request is pending. The memory model therefore acknowledges one cycle after it sees a request and drops the acknowledge straight away, so every request also spends a cycle waiting. The assertions also assume that coordinates stay within 12 bits and that clear addresses stay below 2^32 - 8, so the 33-bit clear pointer never wraps. The tests keep all corners and clear ranges in small windows near the origin or near the surface edge to meet this.

// File: rtl/gfx_fill_engine.sv
module gfx_fill_engine #(
  parameter int AW    = 32,
  parameter int SCR_W = 1280,
  parameter int SCR_H = 1024,
  parameter int CW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [5:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_wide,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  input  logic          mem_ack
);
  localparam logic [3:0] I_OP = 4'd0, I_COL = 4'd1, I_CA = 4'd2, I_CB = 4'd3,
                         I_BASE = 4'd4, I_ZF = 4'd5, I_ZL = 4'd6, I_FGO = 4'd7,
                         I_PGO = 4'd8, I_CMD = 4'd9, I_STAT = 4'd10;
  localparam logic [7:0] OP_SOLID = 8'h03;
  localparam logic [31:0] CMD_ZERO = 32'h11;

  typedef enum logic [1:0] {S_IDLE, S_RECT, S_ZERO} st_t;
  st_t st;

  logic [31:0] r_op, r_col, r_ca, r_cb, r_base, r_zf, r_zl;
  logic [CW-1:0] cx, cy, l_xlo, l_xhi, l_yhi;
  logic [31:0] l_mask, l_base, l_zl;
  logic [7:0]  l_col;
  logic        l_solid;
  logic [AW:0] za;

  wire [3:0] idx = reg_addr[5:2];
  wire busy = (st != S_IDLE);

  wire [CW-1:0] ax = r_ca[16 +: CW], ay = r_ca[0 +: CW];
  wire [CW-1:0] bx = r_cb[16 +: CW], by = r_cb[0 +: CW];
  wire [CW-1:0] xlo = (bx < ax) ? bx : ax;
  wire [CW-1:0] xhi = (bx < ax) ? ax : bx;
  wire [CW-1:0] ylo = (by < ay) ? by : ay;
  wire [CW-1:0] yhi = (by < ay) ? ay : by;
  wire narrow = (xhi - xlo) <= CW'(15);

  wire go_fill = reg_we && idx == I_FGO && !busy && r_op[31:24] == OP_SOLID;
  wire go_pix  = reg_we && idx == I_PGO && !busy;
  wire go_zero = reg_we && idx == I_CMD && !busy && reg_wdata == CMD_ZERO && r_zf <= r_zl;

  wire in_bounds = (32'(cx) < SCR_W) && (32'(cy) < SCR_H);
  wire pix_wr = in_bounds && (l_solid || l_mask[31]);
  wire z_wide = (za[2:0] == 3'd0) && (za + (AW+1)'(7) <= {1'b0, l_zl});
  wire [AW:0] za_next = za + (z_wide ? (AW+1)'(8) : (AW+1)'(1));

  assign mem_req  = (st == S_RECT && pix_wr) || st == S_ZERO;
  assign mem_wide = (st == S_ZERO) && z_wide;
  assign mem_addr = (st == S_ZERO) ? za[AW-1:0]
                  : l_base + AW'(cx) + AW'(cy) * AW'(SCR_W);
  assign mem_wdata = (st == S_RECT) ? {56'd0, l_col} : 64'd0;

  always_comb begin
    case (idx)
      I_OP:    reg_rdata = r_op;
      I_COL:   reg_rdata = r_col;
      I_CA:    reg_rdata = r_ca;
      I_CB:    reg_rdata = r_cb;
      I_BASE:  reg_rdata = r_base;
      I_ZF:    reg_rdata = r_zf;
      I_ZL:    reg_rdata = r_zl;
      I_STAT:  reg_rdata = {31'd0, busy};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_op <= '0; r_col <= '0; r_ca <= '0; r_cb <= '0;
      r_base <= '0; r_zf <= '0; r_zl <= '0;
    end else if (reg_we) begin
      case (idx)
        I_OP:   r_op   <= reg_wdata;
        I_COL:  r_col  <= reg_wdata;
        I_CA:   r_ca   <= reg_wdata;
        I_CB:   r_cb   <= reg_wdata;
        I_BASE: r_base <= reg_wdata;
        I_ZF:   r_zf   <= reg_wdata;
        I_ZL:   r_zl   <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cx <= '0; cy <= '0; l_xlo <= '0; l_xhi <= '0; l_yhi <= '0;
      l_mask <= '0; l_base <= '0; l_zl <= '0; l_col <= '0; l_solid <= 1'b0;
      za <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (go_fill || go_pix) begin
            st <= S_RECT;
            cx <= xlo; cy <= ylo;
            l_xlo <= xlo; l_xhi <= xhi; l_yhi <= yhi;
            l_base <= r_base; l_col <= r_col[7:0];
            l_solid <= go_fill;
            l_mask <= go_fill ? 32'd0 : (narrow ? (reg_wdata << 16) : reg_wdata);
          end else if (go_zero) begin
            st <= S_ZERO;
            za <= {1'b0, r_zf};
            l_zl <= r_zl;
          end
        end
        S_RECT: begin
          if (!pix_wr || mem_ack) begin
            l_mask <= l_mask << 1;
            if (cx == l_xhi) begin
              cx <= l_xlo;
              if (cy == l_yhi) st <= S_IDLE;
              else cy <= cy + CW'(1);
            end else begin
              cx <= cx + CW'(1);
            end
          end
        end
        S_ZERO: begin
          if (mem_ack) begin
            za <= za_next;
            if (za_next > {1'b0, l_zl}) st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wide) && $stable(mem_wdata));

  // R9
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_wide |-> mem_addr[2:0] == 3'd0 && ({1'b0, mem_addr} + (AW+1)'(7) <= {1'b0, l_zl}));

  // R8
  zrange_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && st == S_ZERO |-> {1'b0, mem_addr} <= {1'b0, l_zl} && mem_wdata == 64'd0);

  // R10
  ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_we && (idx == I_FGO || idx == I_PGO || idx == I_CMD)
    |=> $stable(l_xlo) && $stable(l_xhi) && $stable(l_yhi) && $stable(l_base) && $stable(l_zl));

  // R4
  walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_RECT |-> cx >= l_xlo && cx <= l_xhi && cy <= l_yhi);

  // R2
  rect_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && st == S_RECT |-> !mem_wide);
endmodule

// File: tb/sim_gfx_fill_engine.sv
module sim_gfx_fill_engine;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [5:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_wide, mem_ack;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;

  int checks = 0, errors = 0, nbyte = 0, nwide = 0;
  logic [7:0] fb [logic [31:0]];

  always #2 clk = ~clk;

  gfx_fill_engine u0 (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_wide(mem_wide),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      if (mem_req && mem_ack) begin
        if (mem_wide) begin
          for (int k = 0; k < 8; k++) fb[mem_addr + 32'(k)] = mem_wdata[8*k +: 8];
          nwide++;
        end else begin
          fb[mem_addr] = mem_wdata[7:0];
          nbyte++;
        end
      end
      mem_ack <= mem_req && !mem_ack;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int i, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = 6'(i * 4); reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input int i, output logic [31:0] v);
    @(negedge clk); reg_addr = 6'(i * 4); #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    rd(10, s);
    while (s[0]) rd(10, s);
  endtask

  task automatic clear_log();
    fb.delete(); nbyte = 0; nwide = 0;
  endtask

  function automatic logic [31:0] pt(input int x, input int y);
    return (32'(x) << 16) | 32'(y);
  endfunction

  function automatic logic [7:0] px(input logic [31:0] a);
    return fb.exists(a) ? fb[a] : 8'hxx;
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    rd(10, v); chk(v == 0, "R1 status after reset", v, 0);
    rd(1, v);  chk(v == 0, "R1 colour after reset", v, 0);
    chk(mem_req == 0, "R1 no request after reset", mem_req, 0);
    wr(4, 32'h1000); rd(4, v); chk(v == 32'h1000, "R1 base readback", v, 32'h1000);
  endtask

  task automatic t_fill(input bit swap);
    clear_log();
    wr(0, 32'h0300_0000); wr(1, 32'h1A5);
    wr(2, swap ? pt(7, 3) : pt(5, 2)); wr(3, swap ? pt(5, 2) : pt(7, 3));
    wr(7, 0); wait_idle();
    chk(nbyte == 6, swap ? "R4 swapped fill count" : "R2 fill count", nbyte, 6);
    chk(px(32'h1000 + 5 + 2*1280) == 8'hA5, "R2 top-left pixel", px(32'h1000 + 5 + 2*1280), 8'hA5);
    chk(px(32'h1000 + 7 + 3*1280) == 8'hA5, "R4 bottom-right edge included", px(32'h1000 + 7 + 3*1280), 8'hA5);
    chk(!fb.exists(32'h1000 + 4 + 2*1280), "R4 outside pixel untouched", 0, 0);
  endtask

  task automatic t_badop();
    clear_log();
    wr(0, 32'h0100_0000); wr(7, 0);
    repeat (6) @(negedge clk);
    chk(nbyte == 0, "R3 non-fill opcode ignored", nbyte, 0);
    wr(0, 32'h0300_0000);
  endtask

  task automatic t_clip();
    clear_log();
    wr(2, pt(1278, 1022)); wr(3, pt(1281, 1025)); wr(7, 0); wait_idle();
    chk(nbyte == 4, "R5 clipped count", nbyte, 4);
    chk(px(32'h1000 + 1279 + 1023*1280) == 8'hA5, "R5 last visible pixel", px(32'h1000 + 1279 + 1023*1280), 8'hA5);
  endtask

  task automatic t_bitmap();
    clear_log();
    wr(1, 32'h3C); wr(2, pt(10, 0)); wr(3, pt(29, 1)); wr(8, 32'h8000_0001); wait_idle();
    chk(nbyte == 2, "R6 bitmap count", nbyte, 2);
    chk(px(32'h1000 + 10) == 8'h3C, "R6 first mask bit", px(32'h1000 + 10), 8'h3C);
    chk(px(32'h1000 + 21 + 1280) == 8'h3C, "R6 bit 0 at pixel 31", px(32'h1000 + 21 + 1280), 8'h3C);
  endtask

  task automatic t_narrow();
    clear_log();
    wr(2, pt(0, 0)); wr(3, pt(3, 1)); wr(8, 32'h0000_A001); wait_idle();
    chk(nbyte == 2, "R7 narrow shifted count", nbyte, 2);
    chk(px(32'h1000 + 2) == 8'h3C, "R7 narrow pixel 2", px(32'h1000 + 2), 8'h3C);
    clear_log();
    wr(3, pt(15, 1)); wr(8, 32'h0000_8000); wait_idle();
    chk(nbyte == 1 && px(32'h1000) == 8'h3C, "R7 width 15 shifts", nbyte, 1);
    clear_log();
    wr(3, pt(16, 0)); wr(8, 32'h0000_8000); wait_idle();
    chk(nbyte == 1 && px(32'h1000 + 16) == 8'h3C, "R7 width 16 unshifted", nbyte, 1);
  endtask

  task automatic t_zero();
    bit ok = 1;
    clear_log();
    wr(5, 32'h2003); wr(6, 32'h2014); wr(9, 32'h11); wait_idle();
    for (int a = 32'h2003; a <= 32'h2014; a++) if (px(32'(a)) !== 8'h00) ok = 0;
    chk(ok, "R8 range cleared", ok, 1);
    chk(!fb.exists(32'h2002) && !fb.exists(32'h2015), "R8 range ends exact", 0, 0);
    chk(nwide == 1, "R9 wide writes", nwide, 1);
    chk(nbyte == 10, "R9 byte writes", nbyte, 10);
    clear_log();
    wr(9, 32'h12); repeat (4) @(negedge clk);
    chk(nbyte + nwide == 0, "R8 other command ignored", nbyte + nwide, 0);
    wr(5, 32'h2010); wr(6, 32'h200F); wr(9, 32'h11); repeat (4) @(negedge clk);
    chk(nbyte + nwide == 0, "R8 empty range", nbyte + nwide, 0);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    clear_log();
    wr(5, 32'h3000); wr(6, 32'h3001);
    wr(2, pt(0, 0)); wr(3, pt(9, 0)); wr(7, 0);
    rd(10, v); chk(v[0] == 1, "R10 busy while running", v, 1);
    wr(3, pt(20, 0)); wr(7, 0); wr(8, 32'hFFFF_FFFF); wr(9, 32'h11);
    wait_idle();
    chk(nbyte == 10 && nwide == 0, "R10 triggers ignored while busy", nbyte, 10);
    chk(!fb.exists(32'h3000), "R10 clear not started", 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk); rst_n = 1;
    t_reset();
    t_fill(0);
    t_fill(1);
    t_badop();
    t_clip();
    t_bitmap();
    t_narrow();
    t_zero();
    t_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule